// File: doc/BRIEF.md
# Channel Rendezvous and Ready Queue

This block pairs processes that share one processor over synchronised, unbuffered point-to-point channels, and it holds the list of processes that are ready to run. Each channel is a single slot. The slot is either empty or holds the identifier of one waiting process. A request names a channel, a direction (send or receive), the requesting process, its message pointer and a byte count. If the channel is empty, the requester is parked in the slot and told to wait. If another party is already parked there, the rendezvous completes. The block then issues one copy command to an external mover, puts the parked process back on the ready queue, and clears the slot. The block behaves the same way whichever direction arrives first.

The ready queue is a singly linked list with head and tail registers. Processes are appended by a spawn port and by rendezvous wake-ups. A take port removes the process at the head. A small bank of join counters supports the end of a parallel construct: each finishing branch decrements its counter and is told whether to carry on.

Top module: `rdv_sched`

## Requirements
- R1: After reset every channel is empty, the ready queue is empty, no copy command is pending, and `req_ready_o` is 1.
- R2: An accepted request on an empty channel parks the requester. The next cycle shows `resp_valid_o`=1 and `resp_wait_o`=1, and no copy command is raised.
- R3: An accepted request on an occupied channel completes the rendezvous. The next cycle shows `resp_valid_o`=1 with `resp_wait_o`=0, and `xfer_valid_o`=1 with source = the sender's pointer, destination = the receiver's pointer and length = the second arrival's count. This holds whichever direction (`req_out_i`=1 send, 0 receive) arrived first.
- R4: A completed channel returns to empty, so the next request on it parks again.
- R5: On completion the parked process is appended at the tail of the ready queue.
- R6: A copy command holds its fields stable until `xfer_ready_i` is 1. While it is pending, `req_ready_o` is 0 and no request is accepted.
- R7: A spawn appends at the tail. Takes return processes in FIFO order, one cycle after `take_i`, on `run_valid_o`/`run_pid_o`.
- R8: A take on an empty queue, with no append in the same cycle, gives `run_valid_o`=0 and leaves the queue unchanged.
- R9: Appends in one cycle are ordered wake-up first, then spawn, and both go ahead of a take in the same cycle. A take on an empty queue with a same-cycle append returns the appended process.
- R10: `join_set_i` loads counter `join_idx_i` with `join_cnt_i`. `join_end_i` decrements it, and the next cycle gives `join_valid_o`=1 with `join_cont_o`=1 exactly when the result is zero.
- R11: Channels are independent. A process parked on one channel is unaffected by traffic on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Channel request present |
| req_ready_o | output | 1 | Request can be accepted (no copy pending) |
| req_out_i | input | 1 | 1 = send, 0 = receive |
| req_chan_i | input | CH_W | Channel index |
| req_pid_i | input | PID_W | Requesting process |
| req_ptr_i | input | PTR_W | Message pointer |
| req_len_i | input | LEN_W | Byte count |
| resp_valid_o | output | 1 | Response to the request accepted last cycle |
| resp_wait_o | output | 1 | 1 = requester parked, 0 = rendezvous completed |
| xfer_valid_o | output | 1 | Copy command pending |
| xfer_ready_i | input | 1 | Mover accepts the copy command |
| xfer_src_o | output | PTR_W | Sender message pointer |
| xfer_dst_o | output | PTR_W | Receiver message pointer |
| xfer_len_o | output | LEN_W | Byte count |
| spawn_valid_i | input | 1 | Append a process to the ready queue |
| spawn_pid_i | input | PID_W | Process to append |
| take_i | input | 1 | Remove the head of the ready queue |
| run_valid_o | output | 1 | A process was taken |
| run_pid_o | output | PID_W | Taken process |
| join_set_i | input | 1 | Load a join counter |
| join_end_i | input | 1 | Decrement a join counter |
| join_idx_i | input | JI_W | Join counter index |
| join_cnt_i | input | JCNT_W | Load value |
| join_valid_o | output | 1 | Result of last cycle's decrement |
| join_cont_o | output | 1 | 1 = counter reached zero, caller continues |

## Verification
The properties assume a well-formed scheduler around the block. A process identifier appears at most once across the queue and the channel slots. The two parties of a rendezvous have opposite directions. Set and end never target a join counter in the same cycle. The stimulus keeps to these rules: identifiers are handed out so that a process is queued or parked only after it has been taken or has completed, and send and receive always alternate on a channel. A behavioural model, built from integer arrays and a queue, predicts every output cycle by cycle, including a copy stall, a request presented during a stall, and the same-cycle wake, spawn and take ordering.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
  typedef enum logic {
    DIR_RECV = 1'b0,
    DIR_SEND = 1'b1
  } dir_e;
endpackage

// File: rtl/rdv_chan_table.sv
module rdv_chan_table
  import rdv_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int PID_W    = 3,
  parameter int PTR_W    = 16,
  parameter int LEN_W    = 8,
  localparam int CH_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int NPROC   = 1 << PID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  dir_e             req_dir_i,
  input  logic [CH_W-1:0]  req_chan_i,
  input  logic [PID_W-1:0] req_pid_i,
  input  logic [PTR_W-1:0] req_ptr_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             resp_valid_o,
  output logic             resp_wait_o,
  output logic             wake_o,
  output logic [PID_W-1:0] wake_pid_o,
  output logic             xfer_valid_o,
  input  logic             xfer_ready_i,
  output logic [PTR_W-1:0] xfer_src_o,
  output logic [PTR_W-1:0] xfer_dst_o,
  output logic [LEN_W-1:0] xfer_len_o
);
  logic [NUM_CHAN-1:0] full_q;
  logic [PID_W-1:0]    pid_q [NUM_CHAN];
  dir_e                dir_q [NUM_CHAN];
  logic [PTR_W-1:0]    ptr_q [NPROC];

  logic             accept;
  logic             occupied;
  logic [PTR_W-1:0] parked_ptr;

  assign req_ready_o = ~xfer_valid_o;
  assign accept      = req_valid_i & req_ready_o;
  assign occupied    = full_q[req_chan_i];
  assign wake_o      = accept & occupied;
  assign wake_pid_o  = pid_q[req_chan_i];
  assign parked_ptr  = ptr_q[wake_pid_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q       <= '0;
      resp_valid_o <= 1'b0;
      resp_wait_o  <= 1'b0;
      xfer_valid_o <= 1'b0;
      xfer_src_o   <= '0;
      xfer_dst_o   <= '0;
      xfer_len_o   <= '0;
      for (int i = 0; i < NUM_CHAN; i++) begin
        pid_q[i] <= '0;
        dir_q[i] <= DIR_RECV;
      end
    end else begin
      resp_valid_o <= accept;
      if (xfer_valid_o && xfer_ready_i) xfer_valid_o <= 1'b0;
      if (accept) begin
        resp_wait_o <= ~occupied;
        if (!occupied) begin
          full_q[req_chan_i] <= 1'b1;
          pid_q[req_chan_i]  <= req_pid_i;
          dir_q[req_chan_i]  <= req_dir_i;
        end else begin
          full_q[req_chan_i] <= 1'b0;
          xfer_valid_o       <= 1'b1;
          xfer_len_o         <= req_len_i;
          if (req_dir_i == DIR_SEND) begin
            xfer_src_o <= req_ptr_i;
            xfer_dst_o <= parked_ptr;
          end else begin
            xfer_src_o <= parked_ptr;
            xfer_dst_o <= req_ptr_i;
          end
        end
      end
    end
  end

  // pointer saved with the parked process
  always_ff @(posedge clk_i) begin
    if (accept && !occupied) ptr_q[req_pid_i] <= req_ptr_i;
  end
endmodule

// File: rtl/rdv_ready_queue.sv
module rdv_ready_queue #(
  parameter int PID_W  = 3,
  localparam int NPROC = 1 << PID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wake_i,
  input  logic [PID_W-1:0] wake_pid_i,
  input  logic             spawn_i,
  input  logic [PID_W-1:0] spawn_pid_i,
  input  logic             take_i,
  output logic             run_valid_o,
  output logic [PID_W-1:0] run_pid_o,
  output logic             empty_o
);
  logic [PID_W-1:0] nxt_q [NPROC];
  logic [PID_W-1:0] head_q, tail_q;
  logic             empty_q;

  logic             any_app, two_app, empty_a, do_pop, last_one;
  logic [PID_W-1:0] first, last, head_a, tail_a, succ;

  always_comb begin
    any_app = wake_i | spawn_i;
    two_app = wake_i & spawn_i;
    first   = wake_i ? wake_pid_i : spawn_pid_i;
    last    = two_app ? spawn_pid_i : first;
    empty_a = empty_q & ~any_app;
    head_a  = empty_q ? first : head_q;
    tail_a  = any_app ? last : tail_q;
    // successor of head after this cycle's links
    if (two_app && head_a == first)                  succ = spawn_pid_i;
    else if (any_app && !empty_q && head_a == tail_q) succ = first;
    else                                             succ = nxt_q[head_a];
    do_pop   = take_i & ~empty_a;
    last_one = (head_a == tail_a);
  end

  assign empty_o = empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q      <= '0;
      tail_q      <= '0;
      empty_q     <= 1'b1;
      run_valid_o <= 1'b0;
      run_pid_o   <= '0;
    end else begin
      run_valid_o <= do_pop;
      if (do_pop) run_pid_o <= head_a;
      tail_q <= tail_a;
      if (do_pop) begin
        head_q  <= succ;
        empty_q <= last_one;
      end else begin
        head_q  <= head_a;
        empty_q <= empty_a;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (any_app && !empty_q) nxt_q[tail_q] <= first;
    if (two_app)             nxt_q[first]  <= spawn_pid_i;
  end
endmodule

// File: rtl/rdv_join.sv
module rdv_join #(
  parameter int NUM_JOIN = 4,
  parameter int JCNT_W   = 8,
  localparam int JI_W    = (NUM_JOIN > 1) ? $clog2(NUM_JOIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              end_i,
  input  logic [JI_W-1:0]   idx_i,
  input  logic [JCNT_W-1:0] cnt_i,
  output logic              valid_o,
  output logic              cont_o
);
  logic [JCNT_W-1:0] cnt_q [NUM_JOIN];
  logic [JCNT_W-1:0] dec;

  assign dec = cnt_q[idx_i] - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cont_o  <= 1'b0;
      for (int i = 0; i < NUM_JOIN; i++) cnt_q[i] <= '0;
    end else begin
      valid_o <= end_i;
      if (set_i) begin
        cnt_q[idx_i] <= cnt_i;
      end else if (end_i) begin
        cnt_q[idx_i] <= dec;
        cont_o       <= (dec == '0);
      end
    end
  end
endmodule

// File: rtl/rdv_sched.sv
module rdv_sched
  import rdv_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int PID_W    = 3,
  parameter int PTR_W    = 16,
  parameter int LEN_W    = 8,
  parameter int NUM_JOIN = 4,
  parameter int JCNT_W   = 8,
  localparam int CH_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int JI_W    = (NUM_JOIN > 1) ? $clog2(NUM_JOIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_out_i,
  input  logic [CH_W-1:0]   req_chan_i,
  input  logic [PID_W-1:0]  req_pid_i,
  input  logic [PTR_W-1:0]  req_ptr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              resp_valid_o,
  output logic              resp_wait_o,
  output logic              xfer_valid_o,
  input  logic              xfer_ready_i,
  output logic [PTR_W-1:0]  xfer_src_o,
  output logic [PTR_W-1:0]  xfer_dst_o,
  output logic [LEN_W-1:0]  xfer_len_o,
  input  logic              spawn_valid_i,
  input  logic [PID_W-1:0]  spawn_pid_i,
  input  logic              take_i,
  output logic              run_valid_o,
  output logic [PID_W-1:0]  run_pid_o,
  input  logic              join_set_i,
  input  logic              join_end_i,
  input  logic [JI_W-1:0]   join_idx_i,
  input  logic [JCNT_W-1:0] join_cnt_i,
  output logic              join_valid_o,
  output logic              join_cont_o
);
  logic             wake;
  logic [PID_W-1:0] wake_pid;
  logic             q_empty;

  rdv_chan_table #(
    .NUM_CHAN(NUM_CHAN), .PID_W(PID_W), .PTR_W(PTR_W), .LEN_W(LEN_W)
  ) u_chan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_dir_i    (dir_e'(req_out_i)),
    .req_chan_i   (req_chan_i),
    .req_pid_i    (req_pid_i),
    .req_ptr_i    (req_ptr_i),
    .req_len_i    (req_len_i),
    .resp_valid_o (resp_valid_o),
    .resp_wait_o  (resp_wait_o),
    .wake_o       (wake),
    .wake_pid_o   (wake_pid),
    .xfer_valid_o (xfer_valid_o),
    .xfer_ready_i (xfer_ready_i),
    .xfer_src_o   (xfer_src_o),
    .xfer_dst_o   (xfer_dst_o),
    .xfer_len_o   (xfer_len_o)
  );

  rdv_ready_queue #(.PID_W(PID_W)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wake_i      (wake),
    .wake_pid_i  (wake_pid),
    .spawn_i     (spawn_valid_i),
    .spawn_pid_i (spawn_pid_i),
    .take_i      (take_i),
    .run_valid_o (run_valid_o),
    .run_pid_o   (run_pid_o),
    .empty_o     (q_empty)
  );

  rdv_join #(.NUM_JOIN(NUM_JOIN), .JCNT_W(JCNT_W)) u_join (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (join_set_i),
    .end_i   (join_end_i),
    .idx_i   (join_idx_i),
    .cnt_i   (join_cnt_i),
    .valid_o (join_valid_o),
    .cont_o  (join_cont_o)
  );
endmodule

// File: rtl/rdv_sched_sva.sv
module rdv_sched_sva #(
  parameter int PTR_W = 16,
  parameter int LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             resp_valid_o,
  input logic             resp_wait_o,
  input logic             xfer_valid_o,
  input logic             xfer_ready_i,
  input logic [PTR_W-1:0] xfer_src_o,
  input logic [PTR_W-1:0] xfer_dst_o,
  input logic [LEN_W-1:0] xfer_len_o,
  input logic             spawn_valid_i,
  input logic             take_i,
  input logic             run_valid_o,
  input logic             wake,
  input logic             q_empty
);
  p_resp_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> resp_valid_o);

  p_park_no_xfer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_wait_o) |-> !$rose(xfer_valid_o));

  p_done_xfer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_wait_o) |-> xfer_valid_o);

  p_xfer_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && !xfer_ready_i) |=>
      (xfer_valid_o && $stable(xfer_src_o) && $stable(xfer_dst_o) && $stable(xfer_len_o)));

  p_no_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && !xfer_ready_i) |=> !resp_valid_o);

  p_take_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && q_empty && !wake && !spawn_valid_i) |=> !run_valid_o);

  p_take_append_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && (spawn_valid_i || wake)) |=> run_valid_o);
endmodule

bind rdv_sched rdv_sched_sva #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .resp_valid_o  (resp_valid_o),
  .resp_wait_o   (resp_wait_o),
  .xfer_valid_o  (xfer_valid_o),
  .xfer_ready_i  (xfer_ready_i),
  .xfer_src_o    (xfer_src_o),
  .xfer_dst_o    (xfer_dst_o),
  .xfer_len_o    (xfer_len_o),
  .spawn_valid_i (spawn_valid_i),
  .take_i        (take_i),
  .run_valid_o   (run_valid_o),
  .wake          (wake),
  .q_empty       (q_empty)
);

// File: tb/rdv_sched_tb.sv
module rdv_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_out = 0;
  logic [1:0]  req_chan = 0;
  logic [2:0]  req_pid = 0;
  logic [15:0] req_ptr = 0;
  logic [7:0]  req_len = 0;
  logic        xfer_ready = 1;
  logic        spawn_valid = 0;
  logic [2:0]  spawn_pid = 0;
  logic        take = 0;
  logic        join_set = 0, join_end = 0;
  logic [1:0]  join_idx = 0;
  logic [7:0]  join_cnt = 0;

  logic        req_ready, resp_valid, resp_wait, xfer_valid, run_valid, join_valid, join_cont;
  logic [15:0] xfer_src, xfer_dst;
  logic [7:0]  xfer_len;
  logic [2:0]  run_pid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rdv_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_out_i(req_out),
    .req_chan_i(req_chan), .req_pid_i(req_pid), .req_ptr_i(req_ptr), .req_len_i(req_len),
    .resp_valid_o(resp_valid), .resp_wait_o(resp_wait),
    .xfer_valid_o(xfer_valid), .xfer_ready_i(xfer_ready),
    .xfer_src_o(xfer_src), .xfer_dst_o(xfer_dst), .xfer_len_o(xfer_len),
    .spawn_valid_i(spawn_valid), .spawn_pid_i(spawn_pid),
    .take_i(take), .run_valid_o(run_valid), .run_pid_o(run_pid),
    .join_set_i(join_set), .join_end_i(join_end), .join_idx_i(join_idx),
    .join_cnt_i(join_cnt), .join_valid_o(join_valid), .join_cont_o(join_cont)
  );

  // behavioural reference
  bit m_full[4];
  int m_cpid[4];
  int m_ptr[8];
  int m_q[$];
  bit m_xv;
  int m_src, m_dst, m_len;
  int m_jc[4];

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    bit e_rv, e_rw, e_run, e_jv, e_jc, acc;
    int e_pid, p;
    e_rw = 0; e_pid = 0; e_jc = 0;
    acc = req_valid && !m_xv;
    if (m_xv && xfer_ready) m_xv = 0;
    e_rv = acc;
    if (acc) begin
      if (!m_full[req_chan]) begin
        m_full[req_chan] = 1;
        m_cpid[req_chan] = req_pid;
        m_ptr[req_pid]   = req_ptr;
        e_rw = 1;
      end else begin
        p = m_cpid[req_chan];
        m_full[req_chan] = 0;
        m_xv  = 1;
        m_src = req_out ? int'(req_ptr) : m_ptr[p];
        m_dst = req_out ? m_ptr[p] : int'(req_ptr);
        m_len = req_len;
        m_q.push_back(p);
      end
    end
    if (spawn_valid) m_q.push_back(spawn_pid);
    e_run = 0;
    if (take && m_q.size() > 0) begin
      e_run = 1;
      e_pid = m_q.pop_front();
    end
    e_jv = join_end;
    if (join_set) m_jc[join_idx] = join_cnt;
    else if (join_end) begin
      m_jc[join_idx] = (m_jc[join_idx] - 1) & 8'hff;
      e_jc = (m_jc[join_idx] == 0);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "resp_valid", resp_valid, e_rv);
    if (e_rv) check(tag, "resp_wait", resp_wait, e_rw);
    check(tag, "xfer_valid", xfer_valid, m_xv);
    if (m_xv) begin
      check(tag, "xfer_src", xfer_src, m_src);
      check(tag, "xfer_dst", xfer_dst, m_dst);
      check(tag, "xfer_len", xfer_len, m_len);
    end
    check(tag, "req_ready", req_ready, !m_xv);
    check(tag, "run_valid", run_valid, e_run);
    if (e_run) check(tag, "run_pid", run_pid, e_pid);
    check(tag, "join_valid", join_valid, e_jv);
    if (e_jv) check(tag, "join_cont", join_cont, e_jc);
    req_valid = 0; spawn_valid = 0; take = 0; join_set = 0; join_end = 0;
  endtask

  task automatic req(input bit out, input int ch, input int pid, input int ptr, input int len);
    req_valid = 1; req_out = out; req_chan = 2'(ch); req_pid = 3'(pid);
    req_ptr = 16'(ptr); req_len = 8'(len);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_full[i] = 0; m_jc[i] = 0; end
    m_xv = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "req_ready", req_ready, 1);
    check("R1", "xfer_valid", xfer_valid, 0);
    check("R1", "resp_valid", resp_valid, 0);
    check("R1", "run_valid", run_valid, 0);
    take = 1; step("R1 R8 take after reset");

    // R2 send parks on ch0, R3 receive completes, R6 stall
    req(1, 0, 1, 'h100, 4); step("R2 send parks");
    xfer_ready = 0;
    req(0, 0, 2, 'h200, 4); step("R3 R5 receive completes");
    step("R6 stall");
    req(1, 1, 6, 'h600, 2); step("R6 request during stall");
    xfer_ready = 1; step("R6 release");
    step("R6 idle");

    // R3 reverse order on ch1
    req(0, 1, 3, 'h300, 9); step("R2 receive parks");
    req(1, 1, 4, 'h400, 9); step("R3 send completes");
    step("idle");

    // R4 reuse ch0, R11 independent ch2
    req(1, 0, 5, 'h500, 7); step("R4 channel empty again");
    req(0, 2, 6, 'h660, 3); step("R11 ch2 parks");
    req(1, 2, 7, 'h770, 3); step("R11 ch2 completes");
    step("idle");

    // R5 R7 FIFO drain then spawns
    take = 1; step("R5 take");
    take = 1; step("R5 take");
    take = 1; step("R11 take");
    spawn_valid = 1; spawn_pid = 2; step("R7 spawn");
    spawn_valid = 1; spawn_pid = 4; step("R7 spawn");
    take = 1; step("R7 take");
    take = 1; step("R7 take");
    take = 1; step("R8 empty take");
    take = 1; step("R8 empty take again");

    // R9 same-cycle ordering
    spawn_valid = 1; spawn_pid = 0; take = 1; step("R9 spawn+take on empty");
    spawn_valid = 1; spawn_pid = 2; step("R7 spawn");
    req(0, 0, 7, 'h7a0, 7); spawn_valid = 1; spawn_pid = 4; take = 1;
    step("R9 wake+spawn+take");
    take = 1; step("R9 wake before spawn");
    take = 1; step("R9 spawn after wake");
    take = 1; step("R8 empty");

    // R10 join counters
    join_set = 1; join_idx = 1; join_cnt = 3; step("R10 set");
    join_set = 1; join_idx = 2; join_cnt = 1; step("R10 set other");
    join_end = 1; join_idx = 1; step("R10 end nonzero");
    join_end = 1; join_idx = 1; step("R10 end nonzero");
    join_end = 1; join_idx = 2; step("R10 end zero other");
    join_end = 1; join_idx = 1; step("R10 end zero");

    finish_run();
  end
endmodule